// File: doc/BRIEF.md
# Tiled Aperture Address Detiler

The detiler sits on the path of linear accesses into a graphics aperture. It keeps a small table of fence descriptors. Each fence covers a range of 4 KB pages, gives the surface stride, and selects X or Y tiling. Every incoming byte address is compared against all enabled fences. When one covers the address, the address is rewritten so that a linear view of the surface lands on the tiled layout in memory. An address that no fence covers comes back unchanged. Both kinds of result come out one clock after the request.

Each fence is 64 bits wide. It is loaded as two 32-bit words through a narrow configuration port. The two writes are not atomic, so software updates a fence in three steps: clear the low word, load the high word, then load the low word with its enable bit set. A fence whose enable bit is clear never matches. This means a fence part-way through an update is never used for translation.

The tiled offset is tile_base + (row / tile_rows) × stride × tile_rows + (col / tile_width) × 4096 + in-tile offset. Here row and col are the quotient and the remainder of the linear offset divided by the stride. tile_base is the fence start.

Top module: `fence_detiler`

## Requirements
- R1: After reset is released, every fence is disabled and rsp_valid is 0. A later reset disables every fence again, so lookups miss.
- R2: A low-word write sets the fence from these fields: bits 31:12 give the start page, bits 11:2 give the pitch code (stride / 128 − 1), bit 1 selects Y tiling (1) or X tiling (0), and bit 0 is the enable bit. A high-word write sets the inclusive last page from bits 31:12 and ignores bits 11:0.
- R3: An enabled fence covers a request when the request's address bits 31:12 lie between its start page and its last page, both limits included.
- R4: On a miss, rsp_addr equals the request address, rsp_hit is 0 and rsp_fence is 0.
- R5: rsp_valid is 1 exactly in the cycle after a cycle with req_valid at 1, for hits and for misses alike.
- R6: When several enabled fences cover an address, the fence with the lowest index is used, and its index is reported on rsp_fence.
- R7: X tiling uses tiles that are 512 bytes wide and 8 rows tall. The in-tile offset is (row mod 8) × 512 + (col mod 512).
- R8: Y tiling uses tiles that are 128 bytes wide and 32 rows tall, stored as 16-byte columns. The in-tile offset is ((col mod 128) / 16) × 512 + (row mod 32) × 16 + (col mod 16).
- R9: A fence with its enable bit clear never matches. A high-word write does not change any enable bit. A low-word write with bit 0 clear disables the fence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration word write strobe |
| cfg_wr_idx | input | IDX_W | Fence index being written |
| cfg_wr_hi | input | 1 | 1 selects the high word, 0 selects the low word |
| cfg_wr_data | input | 32 | Configuration word |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Linear byte address |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_addr | output | 32 | Tiled address on a hit, request address on a miss |
| rsp_hit | output | 1 | A fence covered the address |
| rsp_fence | output | IDX_W | Index of the fence used (0 on a miss) |

## Verification
The bench uses offsets that cross a tile column, a tile row and a 16-byte Y column, and it uses arbitrary byte offsets. A swapped divisor, a wrong tile width or the X and Y layouts confused would send these to the wrong tile. It probes the first and last byte of a range and the bytes just outside it, which catches an exclusive end page or a one-off start compare. It overlaps two fences and then disables the winner, which exposes reversed priority or a disable that does not take effect. It also loads a fence's high word alone and then a low word with the enable bit clear; a design that arms on a partial update would report a hit there.

// File: rtl/fence_pkg.sv
// Shared geometry and descriptor type for the fence detiler.
// Assumes 32-bit addresses and 4 KB pages; tile sizes are fixed at 4 KB.
package fence_pkg;
    localparam int WORD_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int PAGE_W     = WORD_W - PAGE_SHIFT;
    localparam int PITCH_W    = PAGE_SHIFT - 2;
    localparam int PITCH_LSB  = 2;
    localparam int YSEL_BIT   = 1;
    localparam int EN_BIT     = 0;
    localparam int UNIT_LOG2  = 7;   // stride granule of 128 bytes
    localparam int XW_LOG2    = 9;   // X tile width 512 bytes
    localparam int XR_LOG2    = 3;   // X tile height 8 rows
    localparam int YW_LOG2    = 7;   // Y tile width 128 bytes
    localparam int YR_LOG2    = 5;   // Y tile height 32 rows
    localparam int YC_LOG2    = 4;   // Y column width 16 bytes

    typedef struct packed {
        logic [PAGE_W-1:0]  first_pg;
        logic [PAGE_W-1:0]  last_pg;
        logic [PITCH_W-1:0] pitch;
        logic               ymode;
        logic               en;
    } fence_t;
endpackage

// File: rtl/fence_regfile.sv
// Fence descriptor storage with a 32-bit half-word write port.
// The low word carries start page, pitch, Y select and enable; the high
// word carries only the last page, so it can never enable a fence.
module fence_regfile
    import fence_pkg::*;
#(
    parameter int NUM_FENCES = 4,
    parameter int IDX_W      = $clog2(NUM_FENCES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic                         wr_hi,
    input  logic [WORD_W-1:0]            wr_data,
    output fence_t [NUM_FENCES-1:0]      fences
);
    logic [NUM_FENCES-1:0] en_vec;

    for (genvar g = 0; g < NUM_FENCES; g++) begin : g_fence
        // Update one descriptor on a write addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fences[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                if (wr_hi) begin
                    fences[g].last_pg <= wr_data[WORD_W-1:PAGE_SHIFT];
                end else begin
                    fences[g].first_pg <= wr_data[WORD_W-1:PAGE_SHIFT];
                    fences[g].pitch    <= wr_data[PITCH_LSB+PITCH_W-1:PITCH_LSB];
                    fences[g].ymode    <= wr_data[YSEL_BIT];
                    fences[g].en       <= wr_data[EN_BIT];
                end
            end
        end
        assign en_vec[g] = fences[g].en;
    end

    // R9: a high-word write leaves every enable bit untouched.
    p_hi_keeps_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi) |=> $stable(en_vec));

    // R2: a low-word write takes its enable from bit 0.
    p_lo_sets_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi) |=> (en_vec[$past(wr_idx)] == $past(wr_data[EN_BIT])));
endmodule

// File: rtl/fence_match.sv
// Range compare of a request page against every fence, with a fixed
// lowest-index-wins priority. Purely combinational; clk/rst_n serve checks.
module fence_match
    import fence_pkg::*;
#(
    parameter int NUM_FENCES = 4,
    parameter int IDX_W      = $clog2(NUM_FENCES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [PAGE_W-1:0]                page,
    input  logic [NUM_FENCES-1:0][PAGE_W-1:0] first_pg,
    input  logic [NUM_FENCES-1:0][PAGE_W-1:0] last_pg,
    input  logic [NUM_FENCES-1:0]            en,
    output logic                             hit,
    output logic [IDX_W-1:0]                 idx
);
    logic [NUM_FENCES-1:0] covers;

    for (genvar g = 0; g < NUM_FENCES; g++) begin : g_cmp
        assign covers[g] = en[g] && (page >= first_pg[g]) && (page <= last_pg[g]);
    end

    // Pick the lowest covering index by scanning from the top down.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_FENCES - 1; i >= 0; i--) begin
            if (covers[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // R3: a reported hit lies inside the chosen fence's page range.
    p_hit_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (page >= first_pg[idx] && page <= last_pg[idx]));
endmodule

// File: rtl/tile_xlate.sv
// Rewrites a linear byte address inside a fence into its tiled location.
// Assumes the address is at or above the fence start; stride is
// (pitch + 1) * 128 bytes, so the divisor is never zero.
module tile_xlate
    import fence_pkg::*;
(
    input  logic [WORD_W-1:0]  addr,
    input  logic [PAGE_W-1:0]  first_pg,
    input  logic [PITCH_W-1:0] pitch,
    input  logic               ymode,
    output logic [WORD_W-1:0]  tiled
);
    logic [WORD_W-1:0] base, ofs, units, width_u, row, col, stride;
    logic [WORD_W-1:0] x_off, y_off;

    // Split the offset into row and column of the linear surface.
    always_comb begin
        base    = {first_pg, {PAGE_SHIFT{1'b0}}};
        ofs     = addr - base;
        units   = ofs >> UNIT_LOG2;
        width_u = {{(WORD_W-PITCH_W){1'b0}}, pitch} + 32'd1;
        stride  = width_u << UNIT_LOG2;
        row     = units / width_u;
        col     = ((units % width_u) << UNIT_LOG2)
                | (ofs & ((32'd1 << UNIT_LOG2) - 32'd1));
    end

    // X layout: 512-byte rows, 8 rows per tile.
    always_comb begin
        x_off = (((row >> XR_LOG2) * stride) << XR_LOG2)
              + ((col >> XW_LOG2) << PAGE_SHIFT)
              + ((row & ((32'd1 << XR_LOG2) - 32'd1)) << XW_LOG2)
              + (col & ((32'd1 << XW_LOG2) - 32'd1));
    end

    // Y layout: 16-byte columns of 32 rows, 8 columns per tile.
    always_comb begin
        y_off = (((row >> YR_LOG2) * stride) << YR_LOG2)
              + ((col >> YW_LOG2) << PAGE_SHIFT)
              + (((col & ((32'd1 << YW_LOG2) - 32'd1)) >> YC_LOG2) << (YC_LOG2 + YR_LOG2))
              + ((row & ((32'd1 << YR_LOG2) - 32'd1)) << YC_LOG2)
              + (col & ((32'd1 << YC_LOG2) - 32'd1));
    end

    assign tiled = base + (ymode ? y_off : x_off);
endmodule

// File: rtl/fence_detiler.sv
// Top of the fence detiler: descriptor storage, priority range match,
// tiled address rewrite and a single result register (one-cycle latency
// for hits and misses). Synchronous active-low reset.
module fence_detiler
    import fence_pkg::*;
#(
    parameter int NUM_FENCES = 4,
    localparam int IDX_W     = $clog2(NUM_FENCES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [IDX_W-1:0]  cfg_wr_idx,
    input  logic              cfg_wr_hi,
    input  logic [31:0]       cfg_wr_data,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    output logic              rsp_valid,
    output logic [31:0]       rsp_addr,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_fence
);
    fence_t [NUM_FENCES-1:0]            fences;
    logic [NUM_FENCES-1:0][PAGE_W-1:0]  first_v, last_v;
    logic [NUM_FENCES-1:0]              en_v;
    logic                               m_hit;
    logic [IDX_W-1:0]                   m_idx;
    fence_t                             sel;
    logic [WORD_W-1:0]                  tiled;

    fence_regfile #(.NUM_FENCES(NUM_FENCES), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx),
        .wr_hi(cfg_wr_hi), .wr_data(cfg_wr_data), .fences(fences)
    );

    for (genvar g = 0; g < NUM_FENCES; g++) begin : g_split
        assign first_v[g] = fences[g].first_pg;
        assign last_v[g]  = fences[g].last_pg;
        assign en_v[g]    = fences[g].en;
    end

    fence_match #(.NUM_FENCES(NUM_FENCES), .IDX_W(IDX_W)) u_match (
        .clk(clk), .rst_n(rst_n), .page(req_addr[WORD_W-1:PAGE_SHIFT]),
        .first_pg(first_v), .last_pg(last_v), .en(en_v),
        .hit(m_hit), .idx(m_idx)
    );

    assign sel = fences[m_idx];

    tile_xlate u_xlate (
        .addr(req_addr), .first_pg(sel.first_pg), .pitch(sel.pitch),
        .ymode(sel.ymode), .tiled(tiled)
    );

    // Register the translated or passed-through result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_hit   <= 1'b0;
            rsp_fence <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_addr  <= m_hit ? tiled : req_addr;
                rsp_hit   <= m_hit;
                rsp_fence <= m_hit ? m_idx : '0;
            end
        end
    end

    // R5: a request yields a result exactly one cycle later.
    p_rsp_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_rsp_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4: a miss returns the request address untouched.
    p_miss_passthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == $past(req_addr) && rsp_fence == '0));

    // R9: the matcher only selects an enabled descriptor.
    p_hit_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        m_hit |-> sel.en);
endmodule

// File: tb/fence_detiler_tb.sv
module fence_detiler_tb;
    localparam int NF = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_wr_en, cfg_wr_hi;
    logic [IW-1:0] cfg_wr_idx;
    logic [31:0]   cfg_wr_data;
    logic          req_valid;
    logic [31:0]   req_addr;
    logic          rsp_valid, rsp_hit;
    logic [31:0]   rsp_addr;
    logic [IW-1:0] rsp_fence;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fence_detiler #(.NUM_FENCES(NF)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
        .cfg_wr_hi(cfg_wr_hi), .cfg_wr_data(cfg_wr_data), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_hit(rsp_hit), .rsp_fence(rsp_fence)
    );

    typedef struct packed {
        logic [31:0]   a;
        logic [31:0]   e;
        logic          h;
        logic [IW-1:0] f;
    } vec_t;

    // Fence 0: X, stride 1024, pages 0x00100..0x0011F.
    // Fence 1: Y, stride 512, pages 0x00200..0x0020F.
    localparam vec_t VEC [0:13] = '{
        '{32'h0010_0400, 32'h0010_0200, 1'b1, 2'd0},  // R7 next row
        '{32'h0010_0200, 32'h0010_1000, 1'b1, 2'd0},  // R7 next tile column
        '{32'h0010_2000, 32'h0010_2000, 1'b1, 2'd0},  // R7 next tile row
        '{32'h0010_0A37, 32'h0010_1437, 1'b1, 2'd0},  // R7 odd offset
        '{32'h0020_0010, 32'h0020_0200, 1'b1, 2'd1},  // R8 next 16B column
        '{32'h0020_0200, 32'h0020_0010, 1'b1, 2'd1},  // R8 next row
        '{32'h0020_0080, 32'h0020_1000, 1'b1, 2'd1},  // R8 next tile column
        '{32'h0020_4000, 32'h0020_4000, 1'b1, 2'd1},  // R8 next tile row
        '{32'h0020_0295, 32'h0020_1215, 1'b1, 2'd1},  // R8 odd offset
        '{32'h0030_0000, 32'h0030_0000, 1'b0, 2'd0},  // R4 miss
        '{32'h0020_FFFC, 32'h0020_FFFC, 1'b1, 2'd1},  // R3 last byte
        '{32'h0021_0000, 32'h0021_0000, 1'b0, 2'd0},  // R3 past end
        '{32'h000F_FFFC, 32'h000F_FFFC, 1'b0, 2'd0},  // R3 before start
        '{32'h0011_FFF0, 32'h0011_FFF0, 1'b1, 2'd0}   // R3 last page
    };

    task automatic chk(input string rq, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", rq, what, got, exp);
        end
    endtask

    task automatic wr(input int idx, input logic hi, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_idx = IW'(idx); cfg_wr_hi = hi; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Three-step safe load: disable, high word, low word last.
    task automatic load(input int idx, input logic [31:0] lo, input logic [31:0] hi);
        wr(idx, 1'b0, 32'h0);
        wr(idx, 1'b1, hi);
        wr(idx, 1'b0, lo);
    endtask

    task automatic look(input string rq, input logic [31:0] a, input logic [31:0] e,
                        input logic h, input logic [IW-1:0] f);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rq, "rsp_valid", {31'b0, rsp_valid}, 32'd1);
        chk(rq, "rsp_hit", {31'b0, rsp_hit}, {31'b0, h});
        chk(rq, "rsp_addr", rsp_addr, e);
        chk(rq, "rsp_fence", {30'b0, rsp_fence}, {30'b0, f});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        cfg_wr_en = 1'b0; cfg_wr_hi = 1'b0; cfg_wr_idx = '0; cfg_wr_data = '0;
        req_valid = 1'b0; req_addr = '0;
        do_reset();

        // R1: reset state
        chk("R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
        chk("R1", "rsp_hit after reset", {31'b0, rsp_hit}, 32'd0);
        look("R1", 32'h0010_0000, 32'h0010_0000, 1'b0, 2'd0);

        // R5: no request, no result
        @(negedge clk);
        chk("R5", "rsp_valid idle", {31'b0, rsp_valid}, 32'd0);

        load(0, 32'h0010_001D, 32'h0011_F000);  // R2 X, pitch 7, enabled
        load(1, 32'h0020_000F, 32'h0020_F000);  // R2 Y, pitch 3, enabled

        for (int i = 0; i < 14; i++) begin
            look("R7/R8/R3/R4 vector", VEC[i].a, VEC[i].e, VEC[i].h, VEC[i].f);
        end

        // R6: overlapping fence 2 (Y, stride 1024) loses to fence 0
        load(2, 32'h0010_001F, 32'h0011_F000);
        look("R6", 32'h0010_0400, 32'h0010_0200, 1'b1, 2'd0);
        // R9: disabling fence 0 hands the address to fence 2
        wr(0, 1'b0, 32'h0);
        look("R9", 32'h0010_0400, 32'h0010_0010, 1'b1, 2'd2);

        // R9: high word alone must not arm fence 3
        wr(3, 1'b1, 32'h0030_F000);
        look("R9", 32'h0030_0000, 32'h0030_0000, 1'b0, 2'd0);
        // R2: low word with bit 0 clear leaves it disabled
        wr(3, 1'b0, 32'h0030_000C);
        look("R2", 32'h0030_0000, 32'h0030_0000, 1'b0, 2'd0);
        wr(3, 1'b0, 32'h0030_000D);
        look("R2", 32'h0030_0000, 32'h0030_0000, 1'b1, 2'd3);
        // R2: high-word bits 11:0 ignored
        wr(3, 1'b1, 32'h0030_FFFF);
        look("R2", 32'h0031_0000, 32'h0031_0000, 1'b0, 2'd0);
        look("R2", 32'h0030_FFF0, 32'h0030_FFF0, 1'b1, 2'd3);

        // R1: a second reset disables everything again
        do_reset();
        look("R1", 32'h0020_0010, 32'h0020_0010, 1'b0, 2'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule